// File: doc/BRIEF.md
# Parallel Priority Interrupt Controller

This block collects a small set of peripheral interrupt request lines and decides which one the processor should serve. Each line first passes through its own mask bit. The masked lines then feed a fixed-priority encoder, where the lowest-numbered active line wins. A status flop records, once per clock, whether any masked request is pending, and the index of the winner is captured alongside it. A separate enable flop, which only software writes can change, gates that status to form the single interrupt line seen by the processor.

The processor pulses an instruction-end strobe at every instruction boundary. If that strobe arrives while both the enable flop and the status flop are set, the interrupt is taken. On the next cycle the block drives an acknowledge pulse together with a vector address, which is a fixed base plus the winner's index. In the same step the block clears the enable flop, so no further interrupt can be taken until software sets it again. Software writes the mask and the enable bit through one small register write port, where a select input chooses the target.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable flop, the status flop and all mask bits are 0, so `irq_o`, `ack_o` and `vector_o` are all 0.
- R2: A request line whose mask bit is 0 never contributes to `irq_o` or to the vector. A write with `wr_sel_i`=0 loads the mask from `wr_data_i`, where bit i masks source i (1 = allowed).
- R3: When several masked requests are active, the source with the lowest index wins.
- R4: The status flop takes the "any masked request" value at every clock edge. `irq_o` equals enable AND status, so it follows a request change one cycle later and drops one cycle after the requests go away.
- R5: The enable flop changes only on a write with `wr_sel_i`=1, which loads `wr_data_i[0]`, or on a taken interrupt. Requests alone never set it.
- R6: An interrupt is taken only on a cycle with `instr_end_i`=1, enable=1 and status=1. `ack_o` then goes high on the following cycle, for exactly one cycle.
- R7: Taking an interrupt clears the enable flop, so `irq_o` is 0 in the acknowledge cycle. A software write of the enable flop in the same cycle as the take loses to the take.
- R8: While `ack_o` is high, `vector_o` equals `VEC_BASE` plus the winner's index, with `VEC_BASE`=8'h40 by default. While `ack_o` is low, `vector_o` is 0.
- R9: While `instr_end_i` stays 0, a pending interrupt keeps `irq_o` high and produces no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Peripheral request lines, bit 0 highest priority |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 mask, 1 enable bit |
| wr_data_i | input | NUM_SRC | Write data (mask bits, or enable in bit 0) |
| instr_end_i | input | 1 | Instruction boundary strobe from the processor |
| irq_o | output | 1 | Interrupt line to the processor |
| ack_o | output | 1 | One-cycle interrupt acknowledge |
| vector_o | output | VEC_W | Vector address, valid with ack_o |

## Verification
The bench builds the block with its defaults: four sources, an 8-bit vector and base 8'h40. With four sources there are only sixteen mask values and sixteen request patterns, so the sweep covers every combination of the two. That settles masking, the lowest-index win and the vector arithmetic for every winner, all against expected values the bench computes itself. Directed sequences then cover the cases outside the sweep: a request held without a boundary strobe, requests arriving while the block is disabled, the status flop dropping after the requests go away, and a take that collides with a software enable write.

// File: rtl/pic_pkg.sv
package pic_pkg;

    // Target of a software register write
    typedef enum logic {
        WSEL_MASK   = 1'b0,
        WSEL_ENABLE = 1'b1
    } wsel_e;

    // Processor-visible flag pair
    typedef struct packed {
        logic enable;
        logic status;
    } irq_flags_t;

endpackage

// File: rtl/pic_mask_bank.sv
module pic_mask_bank #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  pic_pkg::wsel_e     wr_sel,
    input  logic [NUM_SRC-1:0] wr_data,
    input  logic [NUM_SRC-1:0] req,
    output logic [NUM_SRC-1:0] gated
);
    import pic_pkg::*;

    logic [NUM_SRC-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_en && wr_sel == WSEL_MASK) begin
            mask_q <= wr_data;
        end
    end

    // One gate per source
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
        assign gated[g] = req[g] & mask_q[g];
    end

endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
    parameter int NUM_SRC = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_SRC-1:0] lines,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    // seen[i]: some lower-indexed line is active
    logic [NUM_SRC:0]   seen;
    logic [NUM_SRC-1:0] hit;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
        assign hit[g]    = lines[g] & ~seen[g];
        assign seen[g+1] = seen[g] | lines[g];
    end

    assign any = seen[NUM_SRC];

    // hit is one-hot or zero: OR together the index of the single hit
    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (hit[i]) begin
                idx = idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pic_flags.sv
module pic_flags #(
    parameter int IDX_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                any_req,
    input  logic [IDX_W-1:0]    win_idx,
    input  logic                sw_wr,
    input  logic                sw_val,
    input  logic                take,
    output pic_pkg::irq_flags_t flags,
    output logic [IDX_W-1:0]    idx_q
);
    import pic_pkg::*;

    irq_flags_t fl_q;
    logic [IDX_W-1:0] win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q  <= '0;
            win_q <= '0;
        end else begin
            // status tracks the encoder every cycle
            fl_q.status <= any_req;
            win_q       <= win_idx;
            // taking the interrupt has precedence over a software write
            if (take) begin
                fl_q.enable <= 1'b0;
            end else if (sw_wr) begin
                fl_q.enable <= sw_val;
            end
        end
    end

    assign flags = fl_q;
    assign idx_q = win_q;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int                          NUM_SRC  = 4,
    parameter int                          VEC_W    = 8,
    parameter logic [VEC_W-1:0]            VEC_BASE = 8'h40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               wr_en_i,
    input  logic               wr_sel_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    input  logic               instr_end_i,
    output logic               irq_o,
    output logic               ack_o,
    output logic [VEC_W-1:0]   vector_o
);
    import pic_pkg::*;

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    wsel_e              sel;
    logic [NUM_SRC-1:0] gated;
    logic               any_req;
    logic [IDX_W-1:0]   win_idx;
    logic [IDX_W-1:0]   held_idx;
    irq_flags_t         flags;
    logic               take;
    logic               ack_q;
    logic [VEC_W-1:0]   vec_q;

    assign sel = wsel_e'(wr_sel_i);

    pic_mask_bank #(.NUM_SRC(NUM_SRC)) mask_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_sel  (sel),
        .wr_data (wr_data_i),
        .req     (req_i),
        .gated   (gated)
    );

    pic_prio_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) enc_i (
        .lines (gated),
        .any   (any_req),
        .idx   (win_idx)
    );

    pic_flags #(.IDX_W(IDX_W)) flags_i (
        .clk     (clk),
        .rst     (rst),
        .any_req (any_req),
        .win_idx (win_idx),
        .sw_wr   (wr_en_i && sel == WSEL_ENABLE),
        .sw_val  (wr_data_i[0]),
        .take    (take),
        .flags   (flags),
        .idx_q   (held_idx)
    );

    assign irq_o = flags.enable & flags.status;
    assign take  = instr_end_i & irq_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= 1'b0;
            vec_q <= '0;
        end else begin
            ack_q <= take;
            vec_q <= take ? (VEC_BASE + VEC_W'(held_idx)) : '0;
        end
    end

    assign ack_o    = ack_q;
    assign vector_o = vec_q;

endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
    parameter int               NUM_SRC  = 4,
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h40
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] req_i,
    input logic               instr_end_i,
    input logic               irq_o,
    input logic               ack_o,
    input logic [VEC_W-1:0]   vector_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (!irq_o && !ack_o && vector_o == '0));

    // R4
    irq_needs_req_chk: assert property (@(posedge clk) disable iff (rst) irq_o |-> $past(|req_i));

    // R6
    ack_cause_chk: assert property (@(posedge clk) disable iff (rst) ack_o |-> $past(instr_end_i && irq_o));

    // R6
    ack_single_chk: assert property (@(posedge clk) disable iff (rst) ack_o |=> !ack_o);

    // R7
    ack_clears_irq_chk: assert property (@(posedge clk) disable iff (rst) ack_o |-> !irq_o);

    // R8
    vec_idle_zero_chk: assert property (@(posedge clk) disable iff (rst) !ack_o |-> vector_o == '0);

    // R3
    vec_range_chk: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (vector_o >= VEC_BASE && vector_o < VEC_BASE + VEC_W'(NUM_SRC)));

endmodule

bind prio_irq_ctrl pic_chk #(
    .NUM_SRC  (NUM_SRC),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .instr_end_i (instr_end_i),
    .irq_o       (irq_o),
    .ack_o       (ack_o),
    .vector_o    (vector_o)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;

    localparam int         N    = 4;
    localparam logic [7:0] BASE = 8'h40;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [N-1:0] wr_data = '0;
    logic         instr_end = 1'b0;
    logic         irq;
    logic         ack;
    logic [7:0]   vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    prio_irq_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .wr_en_i     (wr_en),
        .wr_sel_i    (wr_sel),
        .wr_data_i   (wr_data),
        .instr_end_i (instr_end),
        .irq_o       (irq),
        .ack_o       (ack),
        .vector_o    (vec)
    );

    task automatic check(input string req_tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req_tag, actual, expected, $time);
        end
    endtask

    // one clock: edge, then settle at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sw_write(input logic sel, input logic [N-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk); step(); step();
        rst = 1'b0;
        // R1: reset state, with requests present but all masked
        req = '1;
        step(); step();
        check("R1 irq", int'(irq), 0);
        check("R1 ack", int'(ack), 0);
        check("R1 vec", int'(vec), 0);
        req = '0;

        // R2 R3 R6 R7 R8: full sweep of mask x request
        for (int m = 0; m < 16; m++) begin
            for (int r = 0; r < 16; r++) begin
                logic [N-1:0] act;
                int w;
                act = N'(m) & N'(r);
                w = lowest(act);
                sw_write(1'b0, N'(m));
                req = N'(r);
                sw_write(1'b1, 4'b0001);
                check("R2 R4 irq", int'(irq), int'(act != 0));
                check("R6 idle ack", int'(ack), 0);
                instr_end = 1'b1;
                step();
                instr_end = 1'b0;
                check("R6 ack", int'(ack), int'(act != 0));
                check("R3 R8 vec", int'(vec), (act != 0) ? int'(BASE) + w : 0);
                check("R7 irq after take", int'(irq), 0);
                step();
                check("R6 ack one cycle", int'(ack), 0);
                check("R8 vec idle", int'(vec), 0);
                req = '0;
                sw_write(1'b1, 4'b0000);
            end
        end

        // R5: requests while disabled leave enable at 0
        sw_write(1'b0, 4'b1111);
        req = 4'b0100;
        for (int k = 0; k < 4; k++) begin
            step();
            check("R5 irq disabled", int'(irq), 0);
        end
        instr_end = 1'b1; step(); instr_end = 1'b0;
        check("R5 no ack disabled", int'(ack), 0);

        // R9: pending interrupt waits for a boundary
        sw_write(1'b1, 4'b0001);
        for (int k = 0; k < 5; k++) begin
            check("R9 irq held", int'(irq), 1);
            check("R9 no ack", int'(ack), 0);
            step();
        end
        // R4: status drops one cycle after requests vanish
        req = '0;
        check("R4 irq before edge", int'(irq), 1);
        step();
        check("R4 irq dropped", int'(irq), 0);
        instr_end = 1'b1; step(); instr_end = 1'b0;
        check("R6 no take without status", int'(ack), 0);

        // R7: take wins over a same-cycle enable write
        req = 4'b1010;
        step();
        check("R4 irq raised", int'(irq), 1);
        instr_end = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 4'b0001;
        step();
        instr_end = 1'b0; wr_en = 1'b0;
        check("R7 ack", int'(ack), 1);
        check("R3 vec", int'(vec), int'(BASE) + 1);
        check("R7 enable cleared", int'(irq), 0);
        step();
        check("R7 stays cleared", int'(irq), 0);
        // R5: a write re-enables
        sw_write(1'b1, 4'b0001);
        check("R5 re-enabled", int'(irq), 1);

        finish_run();
    end

endmodule